// File: doc/BRIEF.md
# Masked Error Interrupt Aggregator

This block gathers fault indications from a packet-processing core and turns them into a halt request for that core and a level interrupt to the host processor. It handles three fault classes: parity faults in instruction memory, parity faults in data memory, and coprocessor faults. A coprocessor fault is either a bus error or a parity fault in the switching coprocessor, OR-ed together before masking. Each class records a sticky status bit. A set status bit halts the core and raises the interrupt only when that class's enable bit in a 32-bit configuration register is set.

The host programs the configuration register through a plain write port with byte strobes and reads it back whole. Bit 0 of the register drives a coprocessor error-enable output. While that bit is clear, coprocessor faults are not reported and never reach the status. A switching-coprocessor parity fault also raises a separate one-cycle coprocessor interrupt while reporting is on. Status bits are cleared by writing ones. A fault that arrives in the same cycle as its clear takes priority.

Top module: `err_irq_aggr`

## Requirements
- R1: After reset the configuration register reads 0, the status reads 0, and `core_halt`, `core_irq`, `xcp_irq` and `cp_err_en` are all low.
- R2: A configuration write stores byte b of `cfg_wdata` only where `cfg_be[b]` is 1. The other bytes keep their value. `cfg_rdata` always returns all 32 stored bits.
- R3: A one-cycle fault pulse sets its status bit at the next clock edge whether or not the class is enabled. Status bit 0 is the coprocessor class, bit 1 is data-memory parity and bit 2 is instruction-memory parity.
- R4: Writing 1 to a status bit through `sts_clr_we`/`sts_clr` clears it at the next edge. If a fault of that class arrives in the same cycle, the bit stays set.
- R5: The coprocessor class fault is `bus_err` OR `xcp_par_err`, and it counts only while configuration bit 0 (`cp_err_en`) is 1.
- R6: Enable bits are bit 18 (coprocessor), bit 19 (data memory) and bit 20 (instruction memory). With a class enabled, its fault pulse raises both `core_halt` and `core_irq` at the next clock edge.
- R7: A fault in a disabled class raises neither `core_halt` nor `core_irq`.
- R8: `core_irq` and `core_halt` are levels. They fall at the edge that clears the last enabled set status bit, or at the edge that writes its enable to 0.
- R9: `xcp_irq` is high for the cycle after each cycle in which `xcp_par_err` is 1 and `cp_err_en` is 1. Otherwise it is low.
- R10: Configuration bits other than 0, 18, 19 and 20 are stored and read back but change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte strobes for the configuration write |
| cfg_rdata | output | 32 | Stored configuration value |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 3 | Write-one-to-clear mask for the status bits |
| sts_rdata | output | 3 | Sticky status: bit 2 instruction memory, bit 1 data memory, bit 0 coprocessor |
| imem_par_err | input | 1 | Instruction-memory parity fault pulse |
| dmem_par_err | input | 1 | Data-memory parity fault pulse |
| bus_err | input | 1 | Coprocessor bus error pulse |
| xcp_par_err | input | 1 | Switching-coprocessor parity fault pulse |
| cp_err_en | output | 1 | Coprocessor error-reporting enable (configuration bit 0) |
| core_halt | output | 1 | Halt request to the core |
| core_irq | output | 1 | Level interrupt to the host |
| xcp_irq | output | 1 | Switching-coprocessor parity interrupt |

## Verification
Each fault class is pulsed once with its enable cleared and once with it set. This separates the sticky record, which must be set in both cases, from the halt and interrupt path, which must respond only in the second. Bus and switching-parity faults are driven with reporting off and then on, showing that both feed the coprocessor class and that the gate blocks them. Clears are applied alone, together with a new fault, and as an enable write-back to zero. These runs distinguish set-wins priority and the two ways the interrupt can fall. A configuration pattern that sets every unused bit confirms that those bits are stored but have no effect.

// File: rtl/err_aggr_pkg.sv
package err_aggr_pkg;
  localparam int CFG_W       = 32;
  localparam int CFG_BYTES   = CFG_W / 8;
  localparam int N_CLASS     = 3;
  // class index within status and enable vectors
  localparam int CLS_COP     = 0;
  localparam int CLS_DMEM    = 1;
  localparam int CLS_IMEM    = 2;
  // configuration bit positions
  localparam int CPEN_BIT    = 0;
  localparam int EN_LSB      = 18;   // coprocessor enable, data at +1, instruction at +2
endpackage

// File: rtl/aggr_cfg_reg.sv
module aggr_cfg_reg
  import err_aggr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic [CFG_BYTES-1:0] be,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] cfg_nxt
);
  always_comb begin
    cfg_nxt = cfg_q;
    for (int b = 0; b < CFG_BYTES; b++)
      if (we && be[b]) cfg_nxt[8*b +: 8] = wdata[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end

  // R2: bytes without a strobe keep their value
  generate
    for (genvar b = 0; b < CFG_BYTES; b++) begin : g_chk
      assert_byte_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && be[b]) |=> $stable(cfg_q[8*b +: 8]));
    end
  endgenerate
endmodule

// File: rtl/aggr_status.sv
module aggr_status
  import err_aggr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] err_i,
  input  logic [N_CLASS-1:0] clr_i,
  output logic [N_CLASS-1:0] sts_q,
  output logic [N_CLASS-1:0] sts_nxt
);
  generate
    for (genvar i = 0; i < N_CLASS; i++) begin : g_bit
      // a new fault outranks a clear in the same cycle
      assign sts_nxt[i] = err_i[i] | (sts_q[i] & ~clr_i[i]);

      always_ff @(posedge clk) begin
        if (!rst_n) sts_q[i] <= 1'b0;
        else        sts_q[i] <= sts_nxt[i];
      end

      assert_sticky_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_i[i] |=> sts_q[i]);
      assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !err_i[i]) |=> !sts_q[i]);
    end
  endgenerate
endmodule

// File: rtl/aggr_irq_gen.sv
module aggr_irq_gen
  import err_aggr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] sts_nxt,
  input  logic [N_CLASS-1:0] en_nxt,
  input  logic               xcp_fault,
  output logic               halt_q,
  output logic               irq_q,
  output logic               xcp_irq_q
);
  logic any_nxt;
  assign any_nxt = |(sts_nxt & en_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q    <= 1'b0;
      irq_q     <= 1'b0;
      xcp_irq_q <= 1'b0;
    end else begin
      halt_q    <= any_nxt;
      irq_q     <= any_nxt;
      xcp_irq_q <= xcp_fault;
    end
  end

  assert_xcp_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xcp_fault |=> xcp_irq_q);
endmodule

// File: rtl/err_irq_aggr.sv
module err_irq_aggr
  import err_aggr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  input  logic        sts_clr_we,
  input  logic [2:0]  sts_clr,
  output logic [2:0]  sts_rdata,
  input  logic        imem_par_err,
  input  logic        dmem_par_err,
  input  logic        bus_err,
  input  logic        xcp_par_err,
  output logic        cp_err_en,
  output logic        core_halt,
  output logic        core_irq,
  output logic        xcp_irq
);
  logic [CFG_W-1:0]   cfg_q, cfg_nxt;
  logic [N_CLASS-1:0] err_vec, clr_vec, sts_q, sts_nxt, en_q, en_nxt;
  logic               cop_fault, xcp_fault;

  aggr_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .be(cfg_be),
    .cfg_q(cfg_q), .cfg_nxt(cfg_nxt)
  );

  assign cp_err_en = cfg_q[CPEN_BIT];
  assign en_q      = cfg_q[EN_LSB +: N_CLASS];
  assign en_nxt    = cfg_nxt[EN_LSB +: N_CLASS];

  // coprocessor class: merged before masking, gated by reporting enable
  assign cop_fault = cp_err_en & (bus_err | xcp_par_err);
  assign xcp_fault = cp_err_en & xcp_par_err;

  always_comb begin
    err_vec           = '0;
    err_vec[CLS_COP]  = cop_fault;
    err_vec[CLS_DMEM] = dmem_par_err;
    err_vec[CLS_IMEM] = imem_par_err;
  end
  assign clr_vec = sts_clr_we ? sts_clr : '0;

  aggr_status u_sts (
    .clk(clk), .rst_n(rst_n), .err_i(err_vec), .clr_i(clr_vec),
    .sts_q(sts_q), .sts_nxt(sts_nxt)
  );

  aggr_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .sts_nxt(sts_nxt), .en_nxt(en_nxt),
    .xcp_fault(xcp_fault), .halt_q(core_halt), .irq_q(core_irq),
    .xcp_irq_q(xcp_irq)
  );

  assign cfg_rdata = cfg_q;
  assign sts_rdata = sts_q;

  assert_cop_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_err_en && !sts_q[CLS_COP]) |=> !sts_q[CLS_COP]);
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_vec & en_q) && !cfg_we) |=> (core_irq && core_halt));
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> |(sts_q & en_q));
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_q & en_q)) |-> !core_halt);
endmodule

// File: tb/sim_err_irq_aggr.sv
module sim_err_irq_aggr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, sts_clr_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [2:0]  sts_clr = '0;
  logic imem_par_err = 0, dmem_par_err = 0, bus_err = 0, xcp_par_err = 0;
  logic [31:0] cfg_rdata;
  logic [2:0]  sts_rdata;
  logic cp_err_en, core_halt, core_irq, xcp_irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  err_irq_aggr u0 (.*);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); cfg_we = 1; cfg_wdata = d; cfg_be = be;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk); sts_clr_we = 1; sts_clr = m;
    @(negedge clk); sts_clr_we = 0; sts_clr = '0;
  endtask

  // pulse index: 0 bus, 1 xcp, 2 dmem, 3 imem
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: bus_err = 1; 1: xcp_par_err = 1; 2: dmem_par_err = 1; default: imem_par_err = 1;
    endcase
    @(negedge clk);
    bus_err = 0; xcp_par_err = 0; dmem_par_err = 0; imem_par_err = 0;
  endtask

  task automatic t_reset();
    chk(cfg_rdata, 0, "R1 cfg");
    chk(sts_rdata, 0, "R1 sts");
    chk({core_halt, core_irq, xcp_irq, cp_err_en}, 0, "R1 outputs");
  endtask

  task automatic t_cfg_rw();
    wr_cfg(32'hFFFF_FFFF, 4'hF);
    wr_cfg(32'hA5A5_5A5A, 4'b0101);
    chk(cfg_rdata, 32'hFFA5_FF5A, "R2 partial strobes");
    wr_cfg(32'h0, 4'hF);
    chk(cfg_rdata, 0, "R2 full clear");
  endtask

  task automatic t_masked();
    pulse(3);
    chk(sts_rdata, 3'b100, "R3 imem sticky");
    chk({core_halt, core_irq}, 0, "R7 imem disabled");
    pulse(2);
    chk(sts_rdata, 3'b110, "R3 dmem sticky");
    chk({core_halt, core_irq}, 0, "R7 dmem disabled");
    clr(3'b111);
    chk(sts_rdata, 0, "R4 clear all");
  endtask

  task automatic t_cop_gate();
    pulse(0);
    chk(sts_rdata, 0, "R5 bus gated off");
    pulse(1);
    chk(sts_rdata, 0, "R5 xcp gated off");
    wr_cfg(32'h1, 4'h1);
    chk(cp_err_en, 1, "R5 enable out");
    pulse(0);
    chk(sts_rdata, 3'b001, "R5 bus counted");
    clr(3'b001);
    pulse(1);
    chk(sts_rdata, 3'b001, "R5 xcp counted");
    clr(3'b001);
  endtask

  task automatic t_enabled();
    wr_cfg(32'h001C_0001, 4'hF);
    for (int k = 0; k < 4; k++) begin
      pulse(k);
      chk({core_halt, core_irq}, 2'b11, "R6 enabled fault raises halt and irq");
      clr(3'b111);
      chk({core_halt, core_irq}, 0, "R8 fall after clear");
    end
  endtask

  task automatic t_setwins();
    @(negedge clk); dmem_par_err = 1; sts_clr_we = 1; sts_clr = 3'b010;
    @(negedge clk); dmem_par_err = 0; sts_clr_we = 0; sts_clr = 0;
    chk(sts_rdata, 3'b010, "R4 set wins over clear");
    chk(core_irq, 1, "R4 irq held");
    clr(3'b010);
    chk(sts_rdata, 0, "R4 later clear");
  endtask

  task automatic t_enable_off();
    pulse(3);
    chk(core_irq, 1, "R6 imem irq");
    wr_cfg(32'h000C_0001, 4'hF);
    chk({core_halt, core_irq}, 0, "R8 fall on enable off");
    chk(sts_rdata, 3'b100, "R8 status kept");
    clr(3'b100);
  endtask

  task automatic t_xcp();
    @(negedge clk); xcp_par_err = 1;
    @(negedge clk); xcp_par_err = 0;
    chk(xcp_irq, 1, "R9 xcp irq on");
    @(negedge clk);
    chk(xcp_irq, 0, "R9 xcp irq one cycle");
    clr(3'b111);
    wr_cfg(32'h0, 4'hF);
    pulse(1);
    chk(xcp_irq, 0, "R9 xcp irq gated");
  endtask

  task automatic t_other();
    wr_cfg(32'hFFE3_FFFE, 4'hF);
    chk(cfg_rdata, 32'hFFE3_FFFE, "R10 stored");
    chk(cp_err_en, 0, "R10 no enable");
    pulse(3); pulse(0);
    chk({core_halt, core_irq, xcp_irq}, 0, "R10 no effect on outputs");
    chk(sts_rdata, 3'b100, "R10 status only imem");
    clr(3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_masked();
    t_cop_gate();
    t_enabled();
    t_setwins();
    t_enable_off();
    t_xcp();
    t_other();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule